// File: doc/BRIEF.md
# Interrupt Source Router

This block collects 32 level-sensitive hardware interrupt lines and merges them with a 32-bit software-raised interrupt register to form a raw request vector. Each source is sent either to the fast path or to the normal path by a per-source route-select register. Sources on the normal path are also gated by an enable mask. The fast path is not gated by that mask. Any active fast source drives the single fast interrupt output. The masked normal-path vector is exported in parallel to a downstream priority stage.

Software reaches the block through a plain word-addressed register port, with separate addresses to set and to clear bits. Reads are combinational from the current address. Writes take effect on the next rising clock edge. The port has no handshake: each cycle with write enable high is one write. The interrupt lines are sampled combinationally, so the outputs follow them in the same cycle. `norm_vec` and `fast_irq` are level outputs and do not wait for any ready signal. Any synchronisation of asynchronous lines is the integrator's job.

Top module: `intsrc_router`

## Requirements
- R1: Reading byte offset 0x08 returns the raw vector, which is the bitwise OR of `irq_lines` and the software interrupt register.
- R2: The normal status is raw AND enable AND NOT select. It appears on `norm_vec` and is read at offset 0x00.
- R3: The fast status is raw AND select, with no enable gating, and is read at offset 0x04. `fast_irq` is high exactly when any fast status bit is set.
- R4: A write to 0x10 ORs the data into the enable mask. A write to 0x14 clears every enable bit written as 1. Reading 0x10 returns the mask.
- R5: A write to 0x18 ORs the data into the software interrupt register. A write to 0x1C clears every bit written as 1. Reading 0x18 returns the register.
- R6: A write to 0x0C replaces the whole select register (1 = fast path). Reading 0x0C returns it.
- R7: A write to 0x20 stores only data bit 0 as the protection flag. Reading 0x20 returns that flag in bit 0 and zeros above it.
- R8: A write to 0x00 changes no state.
- R9: Reads of words 0xFE0 to 0xFFC return, in bits 7:0 with zeros above, the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in rising address order.
- R10: Reads of any other offset, including 0x14 and 0x1C, return zero. Writes to offsets other than 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x20 have no effect.
- R11: After reset the enable, select, software and protection registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Hardware interrupt levels, one per source |
| reg_addr | input | 12 | Byte address of register access (word aligned) |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| norm_vec | output | 32 | Masked normal-path vector to the priority stage |
| fast_irq | output | 1 | Fast interrupt request |

## Verification
The bench targets the fast path on a source whose enable bit is clear. A design that gated fast sources with the enable mask would leave `fast_irq` low there. It checks that set and clear writes touch only the bits written as one, so an implementation that overwrote the mask would lose earlier bits. It writes all ones to the read-only status word and to an unmapped word, then reads every register back; a decoder that aliased these addresses would show corrupted state. It also reads 0x14 and 0x1C, which a lazy read mux would alias onto the set registers, and it probes the ends of the identification window, where a wrong byte order or off-by-one index shows up at once.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

  // Word indices (byte offset / 4) of the register map.
  localparam int WI_NSTAT = 0;
  localparam int WI_FSTAT = 1;
  localparam int WI_RAW   = 2;
  localparam int WI_SEL   = 3;
  localparam int WI_ENSET = 4;
  localparam int WI_ENCLR = 5;
  localparam int WI_SWSET = 6;
  localparam int WI_SWCLR = 7;
  localparam int WI_PROT  = 8;

  // Number of identification words at the top of the address space.
  localparam int ID_WORDS = 8;

  typedef struct packed {
    logic sel_wr;
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic prot_wr;
  } wstb_t;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h90;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/intsrc_wdec.sv
module intsrc_wdec #(
  parameter int WW = 10
) (
  input  logic                  we,
  input  logic [WW-1:0]         word,
  output intsrc_pkg::wstb_t     wstb
);
  import intsrc_pkg::*;

  localparam logic [WW-1:0] A_SEL   = WW'(WI_SEL);
  localparam logic [WW-1:0] A_ENSET = WW'(WI_ENSET);
  localparam logic [WW-1:0] A_ENCLR = WW'(WI_ENCLR);
  localparam logic [WW-1:0] A_SWSET = WW'(WI_SWSET);
  localparam logic [WW-1:0] A_SWCLR = WW'(WI_SWCLR);
  localparam logic [WW-1:0] A_PROT  = WW'(WI_PROT);

  // Status words, raw, identification and unmapped words produce no strobe.
  always_comb begin
    wstb         = '0;
    wstb.sel_wr  = we && (word == A_SEL);
    wstb.en_set  = we && (word == A_ENSET);
    wstb.en_clr  = we && (word == A_ENCLR);
    wstb.sw_set  = we && (word == A_SWSET);
    wstb.sw_clr  = we && (word == A_SWCLR);
    wstb.prot_wr = we && (word == A_PROT);
  end

endmodule

// File: rtl/intsrc_regs.sv
module intsrc_regs #(
  parameter int NSRC = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  intsrc_pkg::wstb_t     wstb,
  input  logic [NSRC-1:0]       wdata,
  output logic [NSRC-1:0]       en_q,
  output logic [NSRC-1:0]       sel_q,
  output logic [NSRC-1:0]       soft_q,
  output logic                  prot_q
);

  // One slice per source: set/clear mask bit, set/clear soft bit, route bit.
  for (genvar i = 0; i < NSRC; i++) begin : g_slice
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        soft_q[i] <= 1'b0;
        sel_q[i]  <= 1'b0;
      end else begin
        if (wstb.en_set && wdata[i])      en_q[i] <= 1'b1;
        else if (wstb.en_clr && wdata[i]) en_q[i] <= 1'b0;
        if (wstb.sw_set && wdata[i])      soft_q[i] <= 1'b1;
        else if (wstb.sw_clr && wdata[i]) soft_q[i] <= 1'b0;
        if (wstb.sel_wr)                  sel_q[i] <= wdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            prot_q <= 1'b0;
    else if (wstb.prot_wr) prot_q <= wdata[0];
  end

  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.en_set |=> ((en_q & $past(wdata)) == $past(wdata)));
  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.en_clr |=> ((en_q & $past(wdata)) == '0));
  assert_sw_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.sw_clr |=> ((soft_q & $past(wdata)) == '0));
  assert_prot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb.prot_wr |=> $stable(prot_q));

endmodule

// File: rtl/intsrc_combine.sv
module intsrc_combine #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] hw_lvl,
  input  logic [NSRC-1:0] soft_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] nstat,
  output logic [NSRC-1:0] fstat,
  output logic            fast
);

  always_comb begin
    raw   = hw_lvl | soft_q;
    nstat = raw & en_q & ~sel_q;
    fstat = raw & sel_q;
    fast  = |fstat;
  end

endmodule

// File: rtl/intsrc_rdmux.sv
module intsrc_rdmux #(
  parameter int NSRC = 32,
  parameter int WW   = 10
) (
  input  logic [WW-1:0]   word,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] nstat,
  input  logic [NSRC-1:0] fstat,
  input  logic [NSRC-1:0] sel_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] soft_q,
  input  logic            prot_q,
  output logic [NSRC-1:0] rdata
);
  import intsrc_pkg::*;

  localparam logic [WW-1:0] A_NSTAT = WW'(WI_NSTAT);
  localparam logic [WW-1:0] A_FSTAT = WW'(WI_FSTAT);
  localparam logic [WW-1:0] A_RAW   = WW'(WI_RAW);
  localparam logic [WW-1:0] A_SEL   = WW'(WI_SEL);
  localparam logic [WW-1:0] A_EN    = WW'(WI_ENSET);
  localparam logic [WW-1:0] A_SW    = WW'(WI_SWSET);
  localparam logic [WW-1:0] A_PROT  = WW'(WI_PROT);
  localparam logic [WW-1:0] A_IDLO  = WW'((1 << WW) - ID_WORDS);

  always_comb begin
    rdata = '0;
    if (word >= A_IDLO) begin
      rdata = {{(NSRC-8){1'b0}}, id_byte(word[2:0])};
    end else begin
      case (word)
        A_NSTAT: rdata = nstat;
        A_FSTAT: rdata = fstat;
        A_RAW:   rdata = raw;
        A_SEL:   rdata = sel_q;
        A_EN:    rdata = en_q;
        A_SW:    rdata = soft_q;
        A_PROT:  rdata = {{(NSRC-1){1'b0}}, prot_q};
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/intsrc_router.sv
module intsrc_router #(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic [NSRC-1:0] norm_vec,
  output logic            fast_irq
);
  import intsrc_pkg::*;

  localparam int WW = AW - 2;

  logic [WW-1:0]   word;
  wstb_t           wstb;
  logic [NSRC-1:0] en_q, sel_q, soft_q;
  logic            prot_q;
  logic [NSRC-1:0] raw, nstat, fstat;

  assign word = reg_addr[AW-1:2];

  intsrc_wdec #(.WW(WW)) u_wdec (
    .we   (reg_we),
    .word (word),
    .wstb (wstb)
  );

  intsrc_regs #(.NSRC(NSRC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wstb   (wstb),
    .wdata  (reg_wdata),
    .en_q   (en_q),
    .sel_q  (sel_q),
    .soft_q (soft_q),
    .prot_q (prot_q)
  );

  intsrc_combine #(.NSRC(NSRC)) u_comb (
    .hw_lvl (irq_lines),
    .soft_q (soft_q),
    .en_q   (en_q),
    .sel_q  (sel_q),
    .raw    (raw),
    .nstat  (nstat),
    .fstat  (fstat),
    .fast   (fast_irq)
  );

  intsrc_rdmux #(.NSRC(NSRC), .WW(WW)) u_rdmux (
    .word   (word),
    .raw    (raw),
    .nstat  (nstat),
    .fstat  (fstat),
    .sel_q  (sel_q),
    .en_q   (en_q),
    .soft_q (soft_q),
    .prot_q (prot_q),
    .rdata  (reg_rdata)
  );

  assign norm_vec = nstat;

  assert_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_vec & fstat) == '0);
  assert_fast_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq |-> (sel_q != '0));
  assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && word == '0) |=>
      ($stable(en_q) && $stable(sel_q) && $stable(soft_q) && $stable(prot_q)));
  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr[1:0] == 2'b00));

endmodule

// File: tb/intsrc_router_bench.sv
`timescale 1ns/1ps
module intsrc_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, norm_vec;
  logic        fast_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intsrc_router u_intsrc_router (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .norm_vec(norm_vec), .fast_irq(fast_irq)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] hw;
    logic [31:0] exp;
    logic        efast;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{1'b0, 12'h010, 32'h0,        32'h0,  32'h0,        1'b0},
    '{1'b1, 12'h010, 32'hF0F00000, 32'h0,  32'h0,        1'b0},
    '{1'b1, 12'h010, 32'h000000FF, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h010, 32'h0,        32'h0,  32'hF0F000FF, 1'b0},
    '{1'b1, 12'h014, 32'h000000FF, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h010, 32'h0,        32'h0,  32'hF0F00000, 1'b0},
    '{1'b1, 12'h00C, 32'h00000030, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h00C, 32'h0,        32'h0,  32'h00000030, 1'b0},
    '{1'b0, 12'h008, 32'h0,        32'h11, 32'h00000011, 1'b1},
    '{1'b0, 12'h000, 32'h0,        32'h11, 32'h00000000, 1'b1},
    '{1'b0, 12'h004, 32'h0,        32'h11, 32'h00000010, 1'b1},
    '{1'b1, 12'h018, 32'h00100000, 32'h0,  32'h0,        1'b0},
    '{1'b1, 12'h018, 32'h00000200, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h018, 32'h0,        32'h0,  32'h00100200, 1'b0},
    '{1'b0, 12'h000, 32'h0,        32'h0,  32'h00100000, 1'b0},
    '{1'b0, 12'h008, 32'h0,        32'h1,  32'h00100201, 1'b0},
    '{1'b1, 12'h01C, 32'h00100000, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h018, 32'h0,        32'h0,  32'h00000200, 1'b0},
    '{1'b1, 12'h000, 32'hFFFFFFFF, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h010, 32'h0,        32'h0,  32'hF0F00000, 1'b0},
    '{1'b0, 12'h00C, 32'h0,        32'h0,  32'h00000030, 1'b0},
    '{1'b1, 12'h020, 32'hFFFFFFFF, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h020, 32'h0,        32'h0,  32'h00000001, 1'b0},
    '{1'b1, 12'h040, 32'hFFFFFFFF, 32'h0,  32'h0,        1'b0},
    '{1'b0, 12'h040, 32'h0,        32'h0,  32'h00000000, 1'b0},
    '{1'b0, 12'h014, 32'h0,        32'h0,  32'h00000000, 1'b0},
    '{1'b0, 12'hFE0, 32'h0,        32'h0,  32'h00000090, 1'b0},
    '{1'b0, 12'hFE4, 32'h0,        32'h0,  32'h00000011, 1'b0},
    '{1'b0, 12'hFF0, 32'h0,        32'h0,  32'h0000000D, 1'b0},
    '{1'b0, 12'hFFC, 32'h0,        32'h0,  32'h000000B1, 1'b0}
  };

  function automatic string tag_of(input logic [11:0] a);
    if (a >= 12'hFE0) return "R9";
    case (a)
      12'h000: return "R2";
      12'h004: return "R3";
      12'h008: return "R1";
      12'h00C: return "R6";
      12'h010: return "R4";
      12'h018: return "R5";
      12'h020: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 check(tag, "read", reg_rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1..R10 through the register port.
    for (int i = 0; i < NV; i++) begin
      irq_lines = VT[i].hw;
      if (VT[i].we) begin
        wr(VT[i].addr, VT[i].data);
      end else begin
        rd(VT[i].addr, VT[i].exp, tag_of(VT[i].addr));
        check("R3", "fast_irq", {31'b0, fast_irq}, {31'b0, VT[i].efast});
        if (VT[i].addr == 12'h000) check("R2", "norm_vec", norm_vec, VT[i].exp);
      end
    end

    // R11: reset clears enable, select, soft and protection.
    irq_lines = 32'h00000010;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h010, 32'h0, "R11");
    rd(12'h00C, 32'h0, "R11");
    rd(12'h018, 32'h0, "R11");
    rd(12'h020, 32'h0, "R11");
    check("R11", "fast_irq", {31'b0, fast_irq}, 32'h0);

    // R3: fast path on a disabled source.
    irq_lines = 32'h0;
    wr(12'h00C, 32'h80000000);
    irq_lines = 32'h80000000;
    rd(12'h004, 32'h80000000, "R3");
    check("R3", "fast_irq disabled source", {31'b0, fast_irq}, 32'h1);
    check("R2", "norm_vec excludes fast", norm_vec, 32'h0);

    // R8 and R10: writes to status and unmapped words change nothing.
    wr(12'h000, 32'hFFFFFFFF);
    wr(12'h024, 32'hFFFFFFFF);
    wr(12'h800, 32'hFFFFFFFF);
    rd(12'h00C, 32'h80000000, "R8");
    rd(12'h010, 32'h0, "R8");
    rd(12'h018, 32'h0, "R10");
    rd(12'h01C, 32'h0, "R10");

    // R2: normal vector follows enable and lines.
    wr(12'h010, 32'h00000003);
    irq_lines = 32'h00000007;
    @(negedge clk); #1;
    check("R2", "norm_vec", norm_vec, 32'h00000003);
    check("R3", "fast_irq idle", {31'b0, fast_irq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule